// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block is the digital control logic that sits next to an analog-to-digital converter core. It keeps two independent conversion groups. The regular group is for background sampling. The injected group is for conversions that must run as soon as they are requested. Each group holds a list of up to four channel codes and a length field. When a group starts, the controller asks the converter for one channel at a time, in rank order, and stores every result it gets back. A group can start from a software write or from an external trigger line. The group then runs once (single mode) or repeats until the continuous enable is cleared.

The regular group has one data register. Each regular conversion overwrites it and sets the regular done flag. The injected group writes the result of rank k into injected data register k. It sets its own done flag once the last rank has finished. Each flag has its own interrupt enable, and the interrupt line is the OR of the enabled flags. If software writes a sequence register while a conversion is running, the running conversion is abandoned. The controller then restarts, from rank 0, the group whose register was written.

The converter core is reached through a start pulse with a channel code, and it answers with a done pulse and a 16-bit result. In the bench, a behavioural stub takes the place of the core. The stub has a latency of about 14 cycles and returns a result that depends only on the channel.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy, irq and conv_start are 0. The control register (address 0), the status register (address 1), both sequence registers and all data registers read 0.
- R2: Writing the control register with bit 0 set starts the regular group, provided no group is busy. In single mode (control bit 1 = 0), each rank runs once, then busy drops to 0.
- R3: Each finished regular conversion stores its result in the regular data register (address 4) and sets status bit 0. Status bit 0 is cleared by a read of address 4 or by a status write with bit 0 = 0. If a clearing read and a completion fall in the same cycle, the flag stays set.
- R4: Rank k of the injected group stores its result at address 5+k. Status bit 1 is set when the last injected rank finishes. Only a status write with bit 1 = 0 clears it. Reading the injected data does not clear it.
- R5: irq is high exactly when (status bit 0 and control bit 2) or (status bit 1 and control bit 3).
- R6: With control bit 1 = 1, the running group starts rank 0 again right after its last rank, and busy stays high. After control bit 1 is cleared, the group stops at the end of its current pass.
- R7: When the controller is idle, a pulse on trig_reg starts the regular group and a pulse on trig_inj starts the injected group. If both pulse in the same cycle, only the injected group runs. Both triggers, and the software start, are ignored while busy.
- R8: A valid write to the regular sequence register (address 2) or the injected sequence register (address 3) while busy abandons the conversion in flight, whose result is never stored. A new start for rank 0 of the written group follows on the next cycle.
- R9: A sequence word holds a 2-bit length field in bits [1:0], and 5-bit channel codes for ranks 0 to 3 from bit 2 upward, 5 bits per rank. A sequence write that contains any code above 17 is ignored as a whole.
- R10: A group of length field L runs L+1 conversions. Codes 16 and 17 (the internal sensor and reference) convert in either group like any other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears regular flag at address 4) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| trig_reg | input | 1 | External start for the regular group |
| trig_inj | input | 1 | External start for the injected group |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_chan | output | 5 | Channel code for the requested conversion |
| conv_done | input | 1 | Converter result valid pulse |
| conv_data | input | 16 | Converter result |
| busy | output | 1 | A group is being converted |
| irq | output | 1 | Gated interrupt request |

## Verification
The regular done flag can be set by a finished conversion and cleared by a read of the regular data register in the same cycle. The bench watches the done pulse of its own converter stub and issues the data read on exactly the cycle the pulse is presented. It then reads the status register and expects the flag to still be set, because setting takes precedence over the read-clear. Trigger collisions are judged the same way. When both triggers arrive together, the number of start pulses and the flags must show that only the injected group ran.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // register map
    localparam int unsigned ADR_CTRL = 0;
    localparam int unsigned ADR_STAT = 1;
    localparam int unsigned ADR_RSEQ = 2;
    localparam int unsigned ADR_JSEQ = 3;
    localparam int unsigned ADR_RDAT = 4;
    localparam int unsigned ADR_JDAT = 5;

    // control bits
    localparam int unsigned CB_GO   = 0;
    localparam int unsigned CB_CONT = 1;
    localparam int unsigned CB_EIE  = 2;
    localparam int unsigned CB_JIE  = 3;

    // status bits
    localparam int unsigned SB_EOC  = 0;
    localparam int unsigned SB_JEOC = 1;
    localparam int unsigned SB_BUSY = 2;

    typedef enum logic {
        GRP_REG = 1'b0,
        GRP_INJ = 1'b1
    } grp_e;

endpackage

// File: rtl/adc_seq_unpack.sv
module adc_seq_unpack #(
    parameter int unsigned CH_W  = 5,
    parameter int unsigned RANKS = 4
) (
    input  logic [RANKS*CH_W-1:0]       fields,
    output logic [RANKS-1:0][CH_W-1:0]  chans
);
    for (genvar g = 0; g < RANKS; g++) begin : g_rank
        assign chans[g] = fields[g*CH_W +: CH_W];
    end
endmodule

// File: rtl/adc_seq_valid.sv
module adc_seq_valid #(
    parameter int unsigned CH_W   = 5,
    parameter int unsigned RANKS  = 4,
    parameter int unsigned MAX_CH = 17
) (
    input  logic [RANKS*CH_W-1:0] fields,
    output logic                  ok
);
    logic [RANKS-1:0] in_range;

    for (genvar g = 0; g < RANKS; g++) begin : g_rank
        assign in_range[g] = (fields[g*CH_W +: CH_W] <= CH_W'(MAX_CH));
    end

    assign ok = &in_range;
endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq (
    input  logic eoc,
    input  logic jeoc,
    input  logic eie,
    input  logic jie,
    output logic irq
);
    assign irq = (eoc & eie) | (jeoc & jie);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned CH_W   = 5,
    parameter int unsigned MAX_CH = 17,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned RANKS  = 4,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              trig_reg,
    input  logic              trig_inj,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              busy,
    output logic              irq
);
    localparam int unsigned LEN_W = $clog2(RANKS);
    localparam int unsigned FLD_W = RANKS * CH_W;
    localparam int unsigned SEQ_W = LEN_W + FLD_W;

    typedef struct packed {
        logic                          busy;
        grp_e                          grp;
        logic [LEN_W-1:0]              rank;
        logic                          start;
        logic [CH_W-1:0]               chan;
        logic                          cont;
        logic                          eie;
        logic                          jie;
        logic                          eoc;
        logic                          jeoc;
        logic [BUS_W-1:0]              rseq;
        logic [BUS_W-1:0]              jseq;
        logic [DATA_W-1:0]             rdat;
        logic [RANKS-1:0][DATA_W-1:0]  jdat;
    } st_t;

    st_t st_d, st_q;

    logic [RANKS-1:0][CH_W-1:0] rchans, jchans, cur_chans;
    logic [LEN_W-1:0]           cur_len;
    logic                       wseq_ok;
    logic                       wr_ctrl, wr_stat, wr_rseq, wr_jseq, rd_rdat;
    logic                       restart, last;

    adc_seq_unpack #(.CH_W(CH_W), .RANKS(RANKS)) u_runpack (
        .fields (st_q.rseq[LEN_W +: FLD_W]),
        .chans  (rchans)
    );

    adc_seq_unpack #(.CH_W(CH_W), .RANKS(RANKS)) u_junpack (
        .fields (st_q.jseq[LEN_W +: FLD_W]),
        .chans  (jchans)
    );

    adc_seq_valid #(.CH_W(CH_W), .RANKS(RANKS), .MAX_CH(MAX_CH)) u_wvalid (
        .fields (bus_wdata[LEN_W +: FLD_W]),
        .ok     (wseq_ok)
    );

    adc_seq_irq u_irq (
        .eoc  (st_q.eoc),
        .jeoc (st_q.jeoc),
        .eie  (st_q.eie),
        .jie  (st_q.jie),
        .irq  (irq)
    );

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));
    assign wr_stat = bus_wr && (bus_addr == ADDR_W'(ADR_STAT));
    assign wr_rseq = bus_wr && (bus_addr == ADDR_W'(ADR_RSEQ)) && wseq_ok;
    assign wr_jseq = bus_wr && (bus_addr == ADDR_W'(ADR_JSEQ)) && wseq_ok;
    assign rd_rdat = bus_rd && (bus_addr == ADDR_W'(ADR_RDAT));

    assign cur_chans = (st_q.grp == GRP_INJ) ? jchans : rchans;
    assign cur_len   = (st_q.grp == GRP_INJ) ? st_q.jseq[LEN_W-1:0] : st_q.rseq[LEN_W-1:0];
    assign restart   = st_q.busy && (wr_rseq || wr_jseq);
    assign last      = (st_q.rank == cur_len);

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;

        if (wr_ctrl) begin
            st_d.cont = bus_wdata[CB_CONT];
            st_d.eie  = bus_wdata[CB_EIE];
            st_d.jie  = bus_wdata[CB_JIE];
        end
        if (wr_stat) begin
            if (!bus_wdata[SB_EOC])  st_d.eoc  = 1'b0;
            if (!bus_wdata[SB_JEOC]) st_d.jeoc = 1'b0;
        end
        if (rd_rdat) st_d.eoc = 1'b0;

        // completion: flag setting comes after clearing, so set wins
        if (st_q.busy && conv_done && !restart) begin
            if (st_q.grp == GRP_REG) begin
                st_d.rdat = conv_data;
                st_d.eoc  = 1'b1;
            end else begin
                st_d.jdat[st_q.rank] = conv_data;
            end
            if (last) begin
                if (st_q.grp == GRP_INJ) st_d.jeoc = 1'b1;
                if (st_q.cont) begin
                    st_d.rank  = '0;
                    st_d.start = 1'b1;
                    st_d.chan  = cur_chans[0];
                end else begin
                    st_d.busy = 1'b0;
                end
            end else begin
                st_d.rank  = LEN_W'(st_q.rank + 1'b1);
                st_d.start = 1'b1;
                st_d.chan  = cur_chans[LEN_W'(st_q.rank + 1'b1)];
            end
        end

        if (wr_rseq) st_d.rseq = bus_wdata;
        if (wr_jseq) st_d.jseq = bus_wdata;

        if (restart) begin
            st_d.grp   = wr_jseq ? GRP_INJ : GRP_REG;
            st_d.rank  = '0;
            st_d.start = 1'b1;
            st_d.chan  = bus_wdata[LEN_W +: CH_W];
        end else if (!st_q.busy) begin
            if (trig_inj) begin
                st_d.grp   = GRP_INJ;
                st_d.busy  = 1'b1;
                st_d.rank  = '0;
                st_d.start = 1'b1;
                st_d.chan  = jchans[0];
            end else if (trig_reg || (wr_ctrl && bus_wdata[CB_GO])) begin
                st_d.grp   = GRP_REG;
                st_d.busy  = 1'b1;
                st_d.rank  = '0;
                st_d.start = 1'b1;
                st_d.chan  = rchans[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADR_CTRL)) begin
            bus_rdata[CB_CONT] = st_q.cont;
            bus_rdata[CB_EIE]  = st_q.eie;
            bus_rdata[CB_JIE]  = st_q.jie;
        end else if (bus_addr == ADDR_W'(ADR_STAT)) begin
            bus_rdata[SB_EOC]  = st_q.eoc;
            bus_rdata[SB_JEOC] = st_q.jeoc;
            bus_rdata[SB_BUSY] = st_q.busy;
        end else if (bus_addr == ADDR_W'(ADR_RSEQ)) begin
            bus_rdata = st_q.rseq;
        end else if (bus_addr == ADDR_W'(ADR_JSEQ)) begin
            bus_rdata = st_q.jseq;
        end else if (bus_addr == ADDR_W'(ADR_RDAT)) begin
            bus_rdata[DATA_W-1:0] = st_q.rdat;
        end else begin
            for (int k = 0; k < RANKS; k++) begin
                if (bus_addr == ADDR_W'(ADR_JDAT + k)) bus_rdata[DATA_W-1:0] = st_q.jdat[k];
            end
        end
    end

    assign conv_start = st_q.start;
    assign conv_chan  = st_q.chan;
    assign busy       = st_q.busy;

    // observation points for the bound checker
    logic             eoc_flag, jeoc_flag, cont_en, grp_inj;
    logic [SEQ_W-1:0] wr_seq;
    assign eoc_flag  = st_q.eoc;
    assign jeoc_flag = st_q.jeoc;
    assign cont_en   = st_q.cont;
    assign grp_inj   = (st_q.grp == GRP_INJ);
    assign wr_seq    = bus_wdata[SEQ_W-1:0];

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int unsigned CH_W   = 5,
    parameter int unsigned MAX_CH = 17,
    parameter int unsigned RANKS  = 4,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned LEN_W  = 2,
    parameter int unsigned SEQ_W  = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [SEQ_W-1:0]  wr_seq,
    input logic              conv_start,
    input logic              conv_done,
    input logic              busy,
    input logic              irq,
    input logic              eoc_flag,
    input logic              jeoc_flag,
    input logic              cont_en,
    input logic              grp_inj
);
    function automatic logic codes_ok(input logic [SEQ_W-1:0] w);
        logic ok = 1'b1;
        for (int i = 0; i < RANKS; i++) begin
            if (w[LEN_W + i*CH_W +: CH_W] > CH_W'(MAX_CH)) ok = 1'b0;
        end
        return ok;
    endfunction

    logic seq_addr;
    assign seq_addr = (bus_addr == ADDR_W'(2)) || (bus_addr == ADDR_W'(3));

    a_r2_start_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

    a_r7_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done && !bus_wr) |=> !conv_start);

    a_r3_eoc_after_regular: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done && !grp_inj && !bus_wr) |=> eoc_flag);

    a_r8_restart_on_seq_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && seq_addr && codes_ok(wr_seq)) |=> (conv_start && busy));

    a_r5_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (eoc_flag || jeoc_flag));

    a_r6_cont_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done && cont_en && !bus_wr) |=> busy);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .CH_W(CH_W), .MAX_CH(MAX_CH), .RANKS(RANKS), .ADDR_W(ADDR_W),
    .LEN_W(LEN_W), .SEQ_W(SEQ_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wr_seq     (wr_seq),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .busy       (busy),
    .irq        (irq),
    .eoc_flag   (eoc_flag),
    .jeoc_flag  (jeoc_flag),
    .cont_en    (cont_en),
    .grp_inj    (grp_inj)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        trig_reg = 1'b0, trig_inj = 1'b0;
    logic        conv_start;
    logic [4:0]  conv_chan;
    logic        conv_done;
    logic [15:0] conv_data;
    logic        busy, irq;

    int total = 0;
    int bad   = 0;
    int n_starts = 0;
    logic [4:0] last_chan;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_reg(trig_reg), .trig_inj(trig_inj), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
        .busy(busy), .irq(irq)
    );

    function automatic logic [15:0] fres(input int ch);
        return 16'(ch * 1000 + 37);
    endfunction

    function automatic logic [31:0] sw(input int len, input int c0, input int c1,
                                       input int c2, input int c3);
        return 32'(len) | (32'(c0) << 2) | (32'(c1) << 7) | (32'(c2) << 12) | (32'(c3) << 17);
    endfunction

    // behavioural converter stand-in
    int         stub_cnt;
    logic [4:0] stub_ch;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stub_cnt  <= 0;
            conv_done <= 1'b0;
            conv_data <= '0;
            stub_ch   <= '0;
        end else begin
            conv_done <= 1'b0;
            if (conv_start) begin
                stub_cnt <= LATENCY;
                stub_ch  <= conv_chan;
            end else if (stub_cnt != 0) begin
                stub_cnt <= stub_cnt - 1;
                if (stub_cnt == 1) begin
                    conv_done <= 1'b1;
                    conv_data <= fres(int'(stub_ch));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (conv_start) begin
            n_starts  <= n_starts + 1;
            last_chan <= conv_chan;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'(a);
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic r, input logic j);
        @(negedge clk);
        trig_reg = r; trig_inj = j;
        @(negedge clk);
        trig_reg = 1'b0; trig_inj = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int s0;
        int ch[4];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 start", 32'(conv_start), 0);
        for (int a = 0; a < 9; a++) begin
            rd(a, v);
            chk($sformatf("R1 reg%0d", a), v, 0);
        end

        // R2 R3 R10: every legal channel through a one-rank regular group
        for (int c = 0; c <= 17; c++) begin
            wr(2, sw(0, c, 0, 0, 0));
            s0 = n_starts;
            wr(0, 32'h1);
            chk("R2 busy after go", 32'(busy), 1);
            wait_idle();
            chk("R2 one start", 32'(n_starts - s0), 1);
            chk("R10 chan", 32'(last_chan), 32'(c));
            rd(1, v);
            chk("R3 eoc set", v & 32'h3, 32'h1);
            rd(4, v);
            chk($sformatf("R3 data ch%0d", c), v, 32'(fres(c)));
            rd(1, v);
            chk("R3 eoc cleared by read", v & 32'h1, 0);
        end

        // R10 length sweep, regular and injected groups
        for (int len = 0; len < 4; len++) begin
            for (int k = 0; k < 4; k++) ch[k] = (len * 5 + k * 4 + 1) % 18;
            wr(2, sw(len, ch[0], ch[1], ch[2], ch[3]));
            s0 = n_starts;
            wr(0, 32'h1);
            wait_idle();
            chk("R10 regular count", 32'(n_starts - s0), 32'(len + 1));
            rd(4, v);
            chk("R10 regular last data", v, 32'(fres(ch[len])));

            for (int k = 0; k < 4; k++) ch[k] = (len * 3 + k * 7 + 16) % 18;
            wr(3, sw(len, ch[0], ch[1], ch[2], ch[3]));
            wr(1, 32'h0);
            s0 = n_starts;
            pulse(1'b0, 1'b1);
            wait_idle();
            chk("R10 injected count", 32'(n_starts - s0), 32'(len + 1));
            for (int k = 0; k <= len; k++) begin
                rd(5 + k, v);
                chk($sformatf("R4 jdata rank%0d", k), v, 32'(fres(ch[k])));
            end
            rd(1, v);
            chk("R4 jeoc survives data read", v & 32'h2, 32'h2);
        end
        wr(1, 32'h1);
        rd(1, v);
        chk("R4 jeoc cleared by write 0", v & 32'h3, 0);

        // R3 write-0 clear of the regular flag
        wr(2, sw(0, 9, 0, 0, 0));
        wr(0, 32'h1);
        wait_idle();
        wr(1, 32'h2);
        rd(1, v);
        chk("R3 eoc cleared by write 0", v & 32'h1, 0);

        // R5 interrupt gating
        wr(0, 32'h4);
        pulse(1'b1, 1'b0);
        wait_idle();
        chk("R5 irq eoc enabled", 32'(irq), 1);
        wr(1, 32'h0);
        chk("R5 irq after clear", 32'(irq), 0);
        wr(0, 32'h8);
        pulse(1'b1, 1'b0);
        wait_idle();
        chk("R5 eoc masked", 32'(irq), 0);
        pulse(1'b0, 1'b1);
        wait_idle();
        chk("R5 irq jeoc enabled", 32'(irq), 1);
        wr(1, 32'h0);
        wr(0, 32'h0);

        // R7 both triggers together: injected only
        wr(2, sw(0, 3, 0, 0, 0));
        wr(3, sw(1, 1, 2, 0, 0));
        s0 = n_starts;
        pulse(1'b1, 1'b1);
        wait_idle();
        chk("R7 collision count", 32'(n_starts - s0), 2);
        rd(1, v);
        chk("R7 collision flags", v & 32'h3, 32'h2);
        rd(6, v);
        chk("R7 collision jdata1", v, 32'(fres(2)));
        wr(1, 32'h0);

        // R7 triggers ignored while busy
        wr(2, sw(0, 8, 0, 0, 0));
        s0 = n_starts;
        pulse(1'b1, 1'b0);
        repeat (3) @(negedge clk);
        pulse(1'b0, 1'b1);
        pulse(1'b1, 1'b0);
        wr(0, 32'h1);
        wait_idle();
        chk("R7 busy ignores triggers", 32'(n_starts - s0), 1);
        rd(1, v);
        chk("R7 no injected flag", v & 32'h3, 32'h1);
        rd(4, v);
        chk("R7 regular data", v, 32'(fres(8)));

        // R6 continuous mode
        wr(2, sw(1, 4, 6, 0, 0));
        s0 = n_starts;
        wr(0, 32'h3);
        repeat (100) @(negedge clk);
        chk("R6 still busy", 32'(busy), 1);
        chk("R6 repeated starts", 32'((n_starts - s0) >= 5), 1);
        wr(0, 32'h0);
        wait_idle();
        chk("R6 stopped", 32'(busy), 0);
        rd(4, v);
        chk("R6 ends at last rank", v, 32'(fres(6)));
        wr(1, 32'h0);

        // R8 regular sequence rewritten mid-conversion
        wr(2, sw(0, 2, 0, 0, 0));
        s0 = n_starts;
        wr(0, 32'h1);
        repeat (5) @(negedge clk);
        wr(2, sw(0, 11, 0, 0, 0));
        wait_idle();
        chk("R8 restart count", 32'(n_starts - s0), 2);
        chk("R8 restart chan", 32'(last_chan), 11);
        rd(4, v);
        chk("R8 aborted result dropped", v, 32'(fres(11)));

        // R8 injected sequence written during a regular conversion
        wr(1, 32'h0);
        wr(2, sw(0, 12, 0, 0, 0));
        pulse(1'b1, 1'b0);
        repeat (4) @(negedge clk);
        wr(3, sw(0, 17, 0, 0, 0));
        wait_idle();
        rd(1, v);
        chk("R8 switched to injected", v & 32'h3, 32'h2);
        rd(5, v);
        chk("R8 injected data", v, 32'(fres(17)));
        wr(1, 32'h0);

        // R9 illegal codes reject the whole write
        wr(2, sw(2, 5, 6, 7, 0));
        wr(2, sw(3, 1, 1, 18, 1));
        rd(2, v);
        chk("R9 regular write rejected", v, sw(2, 5, 6, 7, 0));
        wr(3, sw(0, 31, 0, 0, 0));
        rd(3, v);
        chk("R9 injected write rejected", v, sw(0, 17, 0, 0, 0));

        // R3 read-clear and completion in the same cycle
        wr(2, sw(0, 7, 0, 0, 0));
        wr(0, 32'h1);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (conv_done) break;
        end
        bus_rd = 1'b1; bus_addr = 4'd4;
        @(negedge clk);
        bus_rd = 1'b0;
        rd(1, v);
        chk("R3 set wins over read clear", v & 32'h1, 32'h1);
        rd(4, v);
        chk("R3 coincident data", v, 32'(fres(7)));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule